// File: doc/BRIEF.md
# Low-Power Stop Entry Sequencer

This block walks the chip into a stop-type low-power state and back out again. The controller raises a stop request and names one of three targets: a full stop, a stop that keeps the bus clock alive, or a very-low-power stop. The sequencer first cuts the processor clock. It then asks every non-processor bus master to quiesce, and after that every bus slave. Once all of them agree, it gates the system and bus clocks. In the very-low-power target it also switches off the clock generators and moves the regulator to its low-power setting.

A wake event reverses these steps in the opposite order and returns the chip to run. A wake that arrives while the entry is still in progress cuts the entry short and unwinds from wherever the sequence has reached. Each handshake phase has a programmable cycle limit. If a module fails to answer within that limit, the sequencer stops and holds a reset request.

Top module: `lp_stop_seq`

## Requirements
- R1: After reset, every clock enable and the generator enable are high, the regulator select is low, all master and slave requests are low, and the stopped flag and the reset request are low.
- R2: On a stop request in run, the processor clock enable drops on the next edge and nothing else changes. On the following edge every master request rises.
- R3: Slave requests stay low until the sequencer has sampled every master acknowledge high. All slave requests then rise on the next edge.
- R4: On the edge after all slave acknowledges are sampled high, the system clock enable drops. The bus clock enable drops too, except when the target is the bus-keeping stop. Targets are encoded on the mode input as 0 for full stop, 1 for bus-keeping stop and 2 for very-low-power stop; 3 behaves as 0.
- R5: For the very-low-power target only, one edge after clock gating, the regulator select rises. On the same edge the generator enable follows the keep-generators input captured with the request.
- R6: The edge after the last entry step raises the stopped flag. All outputs then hold their values until a wake event arrives.
- R7: Exit runs in this order, one step per edge: first regulator and generators are restored (very-low-power only), then system and bus clocks are re-enabled. Next the slave requests fall, and once all slave acknowledges are sampled low the master requests fall. Once all master acknowledges are sampled low, the processor clock is re-enabled.
- R8: A wake event during the master or slave request phase aborts the entry. The sequencer goes straight to releasing the requests already raised and never gates the system or bus clock.
- R9: If any request or release phase lasts beyond the limit input plus one cycles without completing, the sequencer raises the reset request. It then re-enables all clocks, drops all requests, and stays in that state until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_i | input | 1 | Request to enter the stop sequence (sampled in run) |
| mode_i | input | 2 | Target stop type, captured with the request |
| gen_keep_i | input | 1 | Keep clock generators running in very-low-power stop |
| wake_i | input | 1 | Wake event |
| tmo_limit_i | input | TMO_W | Cycle limit for each handshake phase |
| mst_req_o | output | N_MST | Stop request to each bus master |
| mst_ack_i | input | N_MST | Stop acknowledge from each bus master |
| slv_req_o | output | N_SLV | Stop request to each bus slave |
| slv_ack_i | input | N_SLV | Stop acknowledge from each bus slave |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| gen_en_o | output | 1 | Clock generator enable |
| lp_reg_o | output | 1 | Low-power regulator select |
| stopped_o | output | 1 | Stop state reached |
| ack_rst_req_o | output | 1 | Reset request after a failed handshake |

## Verification
The assertions check the ordering invariants on every cycle. The processor clock must be off whenever any master is asked to stop. Slaves may be asked only while all masters are. System gating is allowed only while all slaves are asked, and the bus clock may be gated only together with the system clock. The low-power regulator is allowed only with both clocks gated, the processor clock must come back last, and the reset request, once raised, must stay high. The bench scenarios establish the rest. They cover the exact edge on which each step lands, the mode-dependent bus and generator choices, the abort path, and the cycle count at which a silent master or a stuck slave acknowledge turns into a reset request.

// File: rtl/lp_stop_pkg.sv
package lp_stop_pkg;

  typedef enum logic [1:0] {
    MODE_STOP1 = 2'd0,
    MODE_STOP2 = 2'd1,
    MODE_VLPS  = 2'd2
  } stop_mode_e;

  typedef enum logic [3:0] {
    S_RUN,
    S_CPU_OFF,
    S_MST_REQ,
    S_SLV_REQ,
    S_GATE,
    S_PWR_DN,
    S_STOPPED,
    S_PWR_UP,
    S_CLK_ON,
    S_SLV_REL,
    S_MST_REL,
    S_CPU_ON,
    S_FAULT
  } seq_state_e;

  typedef struct packed {
    logic cpu;
    logic sys;
    logic bus;
    logic gen;
    logic lp;
    logic stp;
    logic rrq;
  } seq_ctl_t;

  localparam seq_ctl_t CTL_RUN = '{cpu: 1'b1, sys: 1'b1, bus: 1'b1, gen: 1'b1,
                                   lp: 1'b0, stp: 1'b0, rrq: 1'b0};

endpackage

// File: rtl/lp_ack_group.sv
module lp_ack_group #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_set,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] req_o,
  output logic         all_up,
  output logic         all_down
);

  for (genvar i = 0; i < W; i++) begin : g_req
    logic r_q;
    always_ff @(posedge clk) begin
      if (rst) r_q <= 1'b0;
      else     r_q <= req_set;
    end
    assign req_o[i] = r_q;
  end

  assign all_up   = &ack_i;
  assign all_down = ~|ack_i;

endmodule

// File: rtl/lp_phase_timer.sv
module lp_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart)     cnt_q <= '0;
    else if (cnt_q != limit) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == limit);

endmodule

// File: rtl/lp_stop_fsm.sv
module lp_stop_fsm
  import lp_stop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic [1:0] mode,
  input  logic       keep,
  input  logic       wake,
  input  logic       m_all,
  input  logic       m_none,
  input  logic       s_all,
  input  logic       s_none,
  input  logic       tmo_hit,
  output logic       restart,
  output logic       mreq_d,
  output logic       sreq_d,
  output seq_ctl_t   ctl_q
);

  seq_state_e st_q, st_d;
  logic [1:0] mode_q, mode_d;
  logic       keep_q, keep_d;
  logic       is_vlps, is_stop2;
  seq_ctl_t   ctl_d;

  always_comb begin
    mode_d = mode_q;
    keep_d = keep_q;
    if (st_q == S_RUN && stop_req) begin
      mode_d = mode;
      keep_d = keep;
    end
  end

  assign is_vlps  = (mode_d == MODE_VLPS);
  assign is_stop2 = (mode_d == MODE_STOP2);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_RUN:     if (stop_req) st_d = S_CPU_OFF;
      S_CPU_OFF: st_d = wake ? S_CPU_ON : S_MST_REQ;
      S_MST_REQ: begin
        if (tmo_hit && !m_all) st_d = S_FAULT;
        else if (wake)         st_d = S_MST_REL;
        else if (m_all)        st_d = S_SLV_REQ;
      end
      S_SLV_REQ: begin
        if (tmo_hit && !s_all) st_d = S_FAULT;
        else if (wake)         st_d = S_SLV_REL;
        else if (s_all)        st_d = S_GATE;
      end
      S_GATE: begin
        if (wake)         st_d = S_CLK_ON;
        else if (is_vlps) st_d = S_PWR_DN;
        else              st_d = S_STOPPED;
      end
      S_PWR_DN:  st_d = wake ? S_PWR_UP : S_STOPPED;
      S_STOPPED: if (wake) st_d = is_vlps ? S_PWR_UP : S_CLK_ON;
      S_PWR_UP:  st_d = S_CLK_ON;
      S_CLK_ON:  st_d = S_SLV_REL;
      S_SLV_REL: begin
        if (s_none)       st_d = S_MST_REL;
        else if (tmo_hit) st_d = S_FAULT;
      end
      S_MST_REL: begin
        if (m_none)       st_d = S_CPU_ON;
        else if (tmo_hit) st_d = S_FAULT;
      end
      S_CPU_ON:  st_d = S_RUN;
      S_FAULT:   st_d = S_FAULT;
      default:   st_d = S_FAULT;
    endcase
  end

  always_comb begin
    ctl_d  = CTL_RUN;
    mreq_d = 1'b0;
    sreq_d = 1'b0;
    unique case (st_d)
      S_CPU_OFF: ctl_d.cpu = 1'b0;
      S_MST_REQ: begin
        ctl_d.cpu = 1'b0;
        mreq_d    = 1'b1;
      end
      S_SLV_REQ, S_CLK_ON: begin
        ctl_d.cpu = 1'b0;
        mreq_d    = 1'b1;
        sreq_d    = 1'b1;
      end
      S_GATE, S_PWR_DN, S_STOPPED, S_PWR_UP: begin
        ctl_d.cpu = 1'b0;
        ctl_d.sys = 1'b0;
        ctl_d.bus = is_stop2;
        mreq_d    = 1'b1;
        sreq_d    = 1'b1;
        if ((st_d == S_PWR_DN) || (st_d == S_STOPPED && is_vlps)) begin
          ctl_d.gen = keep_d;
          ctl_d.lp  = 1'b1;
        end
        ctl_d.stp = (st_d == S_STOPPED);
      end
      S_SLV_REL: begin
        ctl_d.cpu = 1'b0;
        mreq_d    = 1'b1;
      end
      S_MST_REL: ctl_d.cpu = 1'b0;
      S_FAULT:   ctl_d.rrq = 1'b1;
      default:   ctl_d = CTL_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_RUN;
      mode_q <= MODE_STOP1;
      keep_q <= 1'b0;
      ctl_q  <= CTL_RUN;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      keep_q <= keep_d;
      ctl_q  <= ctl_d;
    end
  end

  assign restart = (st_d != st_q);

endmodule

// File: rtl/lp_stop_seq.sv
module lp_stop_seq
  import lp_stop_pkg::*;
#(
  parameter int N_MST = 2,
  parameter int N_SLV = 3,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req_i,
  input  logic [1:0]       mode_i,
  input  logic             gen_keep_i,
  input  logic             wake_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic [N_MST-1:0] mst_req_o,
  input  logic [N_MST-1:0] mst_ack_i,
  output logic [N_SLV-1:0] slv_req_o,
  input  logic [N_SLV-1:0] slv_ack_i,
  output logic             cpu_clk_en_o,
  output logic             sys_clk_en_o,
  output logic             bus_clk_en_o,
  output logic             gen_en_o,
  output logic             lp_reg_o,
  output logic             stopped_o,
  output logic             ack_rst_req_o
);

  logic     m_all, m_none, s_all, s_none;
  logic     mreq_d, sreq_d, restart, tmo_hit;
  seq_ctl_t ctl;

  lp_ack_group #(.W(N_MST)) u_mst (
    .clk(clk), .rst(rst), .req_set(mreq_d), .ack_i(mst_ack_i),
    .req_o(mst_req_o), .all_up(m_all), .all_down(m_none)
  );

  lp_ack_group #(.W(N_SLV)) u_slv (
    .clk(clk), .rst(rst), .req_set(sreq_d), .ack_i(slv_ack_i),
    .req_o(slv_req_o), .all_up(s_all), .all_down(s_none)
  );

  lp_phase_timer #(.CW(TMO_W)) u_tmr (
    .clk(clk), .rst(rst), .restart(restart), .limit(tmo_limit_i),
    .expired(tmo_hit)
  );

  lp_stop_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req(stop_req_i), .mode(mode_i),
    .keep(gen_keep_i), .wake(wake_i), .m_all(m_all), .m_none(m_none),
    .s_all(s_all), .s_none(s_none), .tmo_hit(tmo_hit), .restart(restart),
    .mreq_d(mreq_d), .sreq_d(sreq_d), .ctl_q(ctl)
  );

  assign cpu_clk_en_o  = ctl.cpu;
  assign sys_clk_en_o  = ctl.sys;
  assign bus_clk_en_o  = ctl.bus;
  assign gen_en_o      = ctl.gen;
  assign lp_reg_o      = ctl.lp;
  assign stopped_o     = ctl.stp;
  assign ack_rst_req_o = ctl.rrq;

endmodule

// File: rtl/lp_stop_chk.sv
module lp_stop_chk #(
  parameter int N_MST = 2,
  parameter int N_SLV = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_MST-1:0] mst_req_o,
  input logic [N_MST-1:0] mst_ack_i,
  input logic [N_SLV-1:0] slv_req_o,
  input logic             cpu_clk_en_o,
  input logic             sys_clk_en_o,
  input logic             bus_clk_en_o,
  input logic             lp_reg_o,
  input logic             stopped_o,
  input logic             ack_rst_req_o
);

  assert_cpu_first_R2: assert property (@(posedge clk) disable iff (rst)
    (|mst_req_o) |-> !cpu_clk_en_o);

  assert_slv_after_mst_R3: assert property (@(posedge clk) disable iff (rst)
    (|slv_req_o) |-> (&mst_req_o));

  assert_slv_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(|slv_req_o) |-> $past(&mst_ack_i));

  assert_gate_after_slv_R4: assert property (@(posedge clk) disable iff (rst)
    !sys_clk_en_o |-> (&slv_req_o));

  assert_bus_with_sys_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_clk_en_o |-> !sys_clk_en_o);

  assert_lp_clocks_off_R5: assert property (@(posedge clk) disable iff (rst)
    lp_reg_o |-> (!sys_clk_en_o && !bus_clk_en_o));

  assert_stopped_gated_R6: assert property (@(posedge clk) disable iff (rst)
    stopped_o |-> (!cpu_clk_en_o && !sys_clk_en_o));

  assert_cpu_last_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_en_o) |-> (mst_req_o == '0 && slv_req_o == '0 &&
                             sys_clk_en_o && bus_clk_en_o));

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ack_rst_req_o |=> ack_rst_req_o);

endmodule

bind lp_stop_seq lp_stop_chk #(.N_MST(N_MST), .N_SLV(N_SLV)) u_chk (
  .clk(clk), .rst(rst), .mst_req_o(mst_req_o), .mst_ack_i(mst_ack_i),
  .slv_req_o(slv_req_o), .cpu_clk_en_o(cpu_clk_en_o),
  .sys_clk_en_o(sys_clk_en_o), .bus_clk_en_o(bus_clk_en_o),
  .lp_reg_o(lp_reg_o), .stopped_o(stopped_o), .ack_rst_req_o(ack_rst_req_o)
);

// File: tb/sim_lp_stop_seq.sv
module sim_lp_stop_seq;

  localparam int N  = 2;
  localparam int M  = 3;
  localparam int TW = 8;
  localparam int OW = 7 + N + M;
  localparam logic [N-1:0] MA = '1;
  localparam logic [M-1:0] SA = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 1'b0, keep = 1'b0, wake = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [TW-1:0] tmo = 8'd10;
  logic [N-1:0] mst_req, mst_ack, m_dead = '0, m_hold = '0;
  logic [M-1:0] slv_req, slv_ack, s_dead = '0, s_hold = '0;
  logic cpu, sys, bus, gen, lp, stopped, rrq;

  always #5 clk = ~clk;

  lp_stop_seq #(.N_MST(N), .N_SLV(M), .TMO_W(TW)) u0 (
    .clk(clk), .rst(rst), .stop_req_i(stop_req), .mode_i(mode),
    .gen_keep_i(keep), .wake_i(wake), .tmo_limit_i(tmo),
    .mst_req_o(mst_req), .mst_ack_i(mst_ack),
    .slv_req_o(slv_req), .slv_ack_i(slv_ack),
    .cpu_clk_en_o(cpu), .sys_clk_en_o(sys), .bus_clk_en_o(bus),
    .gen_en_o(gen), .lp_reg_o(lp), .stopped_o(stopped), .ack_rst_req_o(rrq)
  );

  // bus agents: acknowledge one edge after the request
  always @(posedge clk) begin
    if (rst) begin
      mst_ack <= '0;
      slv_ack <= '0;
    end else begin
      mst_ack <= (mst_req | m_hold) & ~m_dead;
      slv_ack <= (slv_req | s_hold) & ~s_dead;
    end
  end

  logic [OW-1:0] obs;
  assign obs = {rrq, stopped, lp, gen, cpu, sys, bus, slv_req, mst_req};

  function automatic logic [OW-1:0] mk(logic c, logic sy, logic b, logic g,
                                       logic l, logic st, logic r,
                                       logic [N-1:0] m, logic [M-1:0] s);
    return {r, st, l, g, c, sy, b, s, m};
  endfunction

  // scoreboard
  string         tag_q[$];
  logic [OW-1:0] exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;

  task automatic chk(input string tag, input logic [OW-1:0] e);
    tag_q.push_back(tag);
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      string         t;
      logic [OW-1:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      n_chk++;
      if (obs !== e) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", t, obs, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    chk("R1 reset state", mk(1,1,1,1,0,0,0,'0,'0));
    tick();
  endtask

  task automatic run_stop(input logic [1:0] md, input logic kp);
    logic b2, vl, gs;
    b2 = (md == 2'd1);
    vl = (md == 2'd2);
    gs = vl ? kp : 1'b1;
    stop_req = 1'b1; mode = md; keep = kp;
    tick();
    stop_req = 1'b0;
    mode = 2'd3; keep = ~kp;   // later changes must not matter: captured
    chk("R2 cpu gated first", mk(0,1,1,1,0,0,0,'0,'0));
    tick(); chk("R2 masters asked", mk(0,1,1,1,0,0,0,MA,'0));
    tick(); chk("R3 slaves wait for acks", mk(0,1,1,1,0,0,0,MA,'0));
    tick(); chk("R3 slaves asked", mk(0,1,1,1,0,0,0,MA,SA));
    tick(); tick();
    chk("R4 clock gating", mk(0,0,b2,1,0,0,0,MA,SA));
    if (vl) begin
      tick(); chk("R5 regulator low", mk(0,0,0,kp,1,0,0,MA,SA));
    end
    tick(); chk("R6 stopped", mk(0,0,b2,gs,vl,1,0,MA,SA));
    repeat (4) tick();
    chk("R6 held", mk(0,0,b2,gs,vl,1,0,MA,SA));
    wake = 1'b1;
    tick();
    wake = 1'b0;
    if (vl) begin
      chk("R7 power restored first", mk(0,0,0,1,0,0,0,MA,SA));
      tick();
    end
    chk("R7 clocks back", mk(0,1,1,1,0,0,0,MA,SA));
    tick(); chk("R7 slaves released", mk(0,1,1,1,0,0,0,MA,'0));
    tick(); tick(); chk("R7 masters released", mk(0,1,1,1,0,0,0,'0,'0));
    tick(); chk("R7 cpu waits for drops", mk(0,1,1,1,0,0,0,'0,'0));
    tick(); chk("R7 cpu last", mk(1,1,1,1,0,0,0,'0,'0));
    mode = 2'd0; keep = 1'b0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    chk("R1 reset state", mk(1,1,1,1,0,0,0,'0,'0));
    tick();

    run_stop(2'd0, 1'b0);   // full stop
    run_stop(2'd1, 1'b0);   // bus-keeping stop
    run_stop(2'd2, 1'b0);   // very-low-power, generators off
    run_stop(2'd2, 1'b1);   // very-low-power, generators kept

    // R8: abort during master phase
    stop_req = 1'b1; mode = 2'd0;
    tick(); stop_req = 1'b0;
    tick();
    wake = 1'b1;
    tick(); wake = 1'b0;
    chk("R8 abort releases masters", mk(0,1,1,1,0,0,0,'0,'0));
    tick(); tick();
    chk("R8 back to run", mk(1,1,1,1,0,0,0,'0,'0));
    tick();

    // R9: silent master
    tmo = 8'd4; m_dead = 2'b01;
    stop_req = 1'b1;
    tick(); stop_req = 1'b0;
    tick();
    repeat (4) tick();
    chk("R9 within limit", mk(0,1,1,1,0,0,0,MA,'0));
    tick();
    chk("R9 reset request", mk(1,1,1,1,0,0,1,'0,'0));
    stop_req = 1'b1; wake = 1'b1;
    repeat (3) tick();
    stop_req = 1'b0; wake = 1'b0;
    chk("R9 sticky", mk(1,1,1,1,0,0,1,'0,'0));
    m_dead = '0;
    do_reset();

    // R9: slave acknowledge stuck high on release
    s_hold = 3'b100;
    stop_req = 1'b1;
    tick(); stop_req = 1'b0;
    for (int i = 0; i < 40 && !stopped; i++) tick();
    wake = 1'b1;
    tick(); wake = 1'b0;
    for (int i = 0; i < 40 && !rrq; i++) tick();
    chk("R9 release timeout", mk(1,1,1,1,0,0,1,'0,'0));
    s_hold = '0;
    do_reset();
    tick();

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule